// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Flags

This block is a small synchronous counter that steps up or down by one on each rising clock edge, while its active-low enable is held low. A parameter picks its range. In decade mode it runs 0 to 9. In binary mode it runs over the full width, which is 0 to 15 at the default width of four bits. The direction input chooses the step. When that input is low the counter goes up, and when it is high the counter goes down.

An active-low load input presets the counter from a data word. It acts without waiting for a clock edge. While load is held low the output follows the data word, and clock edges have no further effect. When load is released, the counter keeps the last word it took. There is also a synchronous, active-high reset that clears the count.

Two flags support cascading several counters:
- **Terminal-count flag.** It is high when the counter would roll over on its next enabled step. That means the maximum value while counting up, or zero while counting down.
- **Active-low ripple flag.** It repeats the terminal-count condition, but only while the clock is low.

Both flags are suppressed while the stage is disabled. This keeps a stalled stage from passing on a carry or a borrow.

Top module: `updn_counter4`

## Requirements
- R1: When reset is high at a rising clock edge and load is inactive (high), the count becomes 0.
- R2: When the enable input is high at a rising edge, the count is unchanged.
- R3: When enable is low at a rising edge, the count becomes the old count plus one if the direction input is low (0 = up). It becomes the old count minus one if the direction input is high (1 = down).
- R4: At the range ends the count wraps. In decade mode, counting up from 9 gives 0 and counting down from 0 gives 9. In binary mode (width 4), counting up from 15 gives 0 and counting down from 0 gives 15.
- R5: While load is low, the output equals the data input without waiting for a clock edge. Load overrides counting and reset. After load is released, the count holds the loaded word.
- R6: In decade mode, a loaded value from 10 to 15 steps up to 0, and steps down to that value minus one.
- R7: The terminal-count output is high exactly when enable is low and one of two cases holds: direction is down (1) and the output is 0, or direction is up (0) and the output is at the mode's maximum.
- R8: The ripple output is low exactly when the terminal-count output is high and the clock is low. It is high at every other time.
- R9: A change on the direction input between clock edges leaves the output count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| en_n | input | 1 | Count enable, active low |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous preset, active low |
| din | input | WIDTH | Preset data word |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag, high at the rollover value of the current direction |
| rco_n | output | 1 | Ripple flag, active low, driven during the low clock phase only |

## Verification
The results arrive at three different times.

Count changes from reset, enable and direction appear one rising edge after the inputs are applied. The bench drives every input at a falling edge and compares the count one time unit after the following rising edge.

A preset, the terminal-count flag and the ripple flag follow their inputs without any clock. These are checked one time unit after the inputs change, while the clock is still low. The same sample also confirms that a change of direction has not moved the count.

The ripple flag is checked a second time in the high clock phase, where it must be inactive. A decade instance and a binary instance share all their stimulus, so the two wrap points are checked side by side.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  function automatic int top_value(input int width, input bit decade);
    return decade ? 9 : ((1 << width) - 1);
  endfunction

endpackage

// File: rtl/updn_step.sv
module updn_step
  import updn_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int MAXV  = 9
) (
  input  logic [WIDTH-1:0] cur,
  input  dir_e             dir,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MAXV);

  always_comb begin
    if (dir == DIR_UP) begin
      // values at or above the top (decade preset of 10..15) return to 0
      nxt = (cur >= TOP) ? '0 : cur + 1'b1;
    end else begin
      nxt = (cur == '0) ? TOP : cur - 1'b1;
    end
  end
endmodule

// File: rtl/updn_state.sv
module updn_state
  import updn_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int MAXV  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic             down,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MAXV);

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)    cnt <= din;
    else if (rst)   cnt <= '0;
    else if (!en_n) cnt <= nxt;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (load_n && $past(load_n) && !$past(rst) && $past(en_n)) |-> $stable(cnt)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (load_n && $past(load_n) && !$past(rst) && !$past(en_n) && !$past(down)
     && $past(cnt) < TOP) |-> cnt == $past(cnt) + 1'b1); // R3

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (load_n && $past(load_n) && !$past(rst) && !$past(en_n) && !$past(down)
     && $past(cnt) == TOP) |-> cnt == '0); // R4

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (load_n && $past(load_n) && !$past(rst) && !$past(en_n) && $past(down)
     && $past(cnt) == '0) |-> cnt == TOP); // R4

  AST_OVER_TOP: assert property (@(posedge clk) disable iff (rst)
    (load_n && $past(load_n) && !$past(rst) && !$past(en_n) && !$past(down)
     && $past(cnt) > TOP) |-> cnt == '0); // R6
endmodule

// File: rtl/updn_term.sv
module updn_term
  import updn_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int MAXV  = 9
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] q,
  input  logic             en_n,
  input  dir_e             dir,
  output logic             tc,
  output logic             rco_n
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MAXV);

  logic at_end;

  always_comb begin
    at_end = (dir == DIR_DOWN) ? (q == '0) : (q == TOP);
    tc     = at_end && !en_n;
    rco_n  = !(tc && !clk);
  end

  always_comb begin
    if (clk === 1'b1) AST_RCO_HIGH_PHASE: assert (rco_n); // R8
  end
endmodule

// File: rtl/updn_counter4.sv
module updn_counter4
  import updn_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic             down,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc,
  output logic             rco_n
);
  localparam int MAXV = top_value(WIDTH, DECADE);

  dir_e             dir;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] nxt;

  assign dir = dir_e'(down);
  // the preset word passes straight through while load is held low
  assign q   = load_n ? cnt : din;

  updn_step #(.WIDTH(WIDTH), .MAXV(MAXV)) u_step (
    .cur (cnt),
    .dir (dir),
    .nxt (nxt)
  );

  updn_state #(.WIDTH(WIDTH), .MAXV(MAXV)) u_state (
    .clk    (clk),
    .rst    (rst),
    .en_n   (en_n),
    .down   (down),
    .load_n (load_n),
    .din    (din),
    .nxt    (nxt),
    .cnt    (cnt)
  );

  updn_term #(.WIDTH(WIDTH), .MAXV(MAXV)) u_term (
    .clk   (clk),
    .q     (q),
    .en_n  (en_n),
    .dir   (dir),
    .tc    (tc),
    .rco_n (rco_n)
  );
endmodule

// File: tb/test_updn_counter4.sv
module test_updn_counter4;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n = 1'b1;
  logic down = 1'b0;
  logic load_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q_d, q_b;
  logic tc_d, tc_b, rco_d, rco_b;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  int md = 0;
  int mb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_counter4 #(.WIDTH(W), .DECADE(1'b1)) i_updn_counter4 (
    .clk(clk), .rst(rst), .en_n(en_n), .down(down), .load_n(load_n),
    .din(din), .q(q_d), .tc(tc_d), .rco_n(rco_d));

  updn_counter4 #(.WIDTH(W), .DECADE(1'b0)) i_bin (
    .clk(clk), .rst(rst), .en_n(en_n), .down(down), .load_n(load_n),
    .din(din), .q(q_b), .tc(tc_b), .rco_n(rco_b));

  function automatic int step_of(input int v, input bit dn, input int top);
    if (!dn) return (v >= top) ? 0 : v + 1;
    return (v == 0) ? top : v - 1;
  endfunction

  function automatic bit tc_of(input int v, input bit dn, input bit en_low, input int top);
    return en_low && (dn ? (v == 0) : (v == top));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock cycle: drive at falling edge, check low phase, then after rising edge
  task automatic cyc(input bit r, input bit e, input bit dn, input bit ld, input int d);
    int vd, vb;
    bit td, tb;
    @(negedge clk);
    rst = r; en_n = e; down = dn; load_n = ld; din = W'(d);
    #1;
    vd = ld ? md : d;
    vb = ld ? mb : d;
    if (!ld) begin
      chk(q_d == W'(d), "R5 load passes data (dec)", q_d, d);
      chk(q_b == W'(d), "R5 load passes data (bin)", q_b, d);
    end else begin
      chk(q_d == W'(md), "R9 no change between edges (dec)", q_d, md);
      chk(q_b == W'(mb), "R9 no change between edges (bin)", q_b, mb);
    end
    td = tc_of(vd, dn, !e, 9);
    tb = tc_of(vb, dn, !e, 15);
    chk(tc_d == td, "R7 terminal count (dec)", tc_d, td);
    chk(tc_b == tb, "R7 terminal count (bin)", tc_b, tb);
    chk(rco_d == !td, "R8 ripple low phase (dec)", rco_d, !td);
    chk(rco_b == !tb, "R8 ripple low phase (bin)", rco_b, !tb);
    @(posedge clk);
    #1;
    if (!ld) begin md = d; mb = d; end
    else if (r) begin md = 0; mb = 0; end
    else if (!e) begin md = step_of(md, dn, 9); mb = step_of(mb, dn, 15); end
    chk(q_d == W'(md), "R1/R2/R3/R4/R6 count after edge (dec)", q_d, md);
    chk(q_b == W'(mb), "R1/R2/R3/R4 count after edge (bin)", q_b, mb);
    chk(rco_d == 1'b1, "R8 ripple idle high phase (dec)", rco_d, 1);
    chk(rco_b == 1'b1, "R8 ripple idle high phase (bin)", rco_b, 1);
  endtask

  initial begin
    int seed = 32'h1D5E;
    void'($urandom(seed));
    cyc(1, 1, 0, 1, 0);                  // R1 reset
    chk(q_d == 0, "R1 reset value", q_d, 0);
    cyc(1, 0, 0, 1, 0);
    repeat (3) cyc(0, 1, 0, 1, 0);       // R2 hold
    repeat (18) cyc(0, 0, 0, 1, 0);      // R3 up, R4 wrap
    repeat (18) cyc(0, 0, 1, 1, 0);      // R3 down, R4 wrap
    cyc(0, 0, 0, 0, 12);                 // R5 load 12
    cyc(0, 0, 0, 1, 0);                  // R6 12 up -> 0
    cyc(0, 1, 0, 0, 13);
    cyc(0, 0, 1, 1, 0);                  // R6 13 down -> 12
    cyc(0, 0, 1, 1, 0);
    cyc(1, 0, 0, 0, 7);                  // R5 load over reset
    cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 1, 1, 0);                  // R9 direction flip, held
    cyc(0, 0, 0, 0, 9);
    cyc(0, 1, 0, 1, 0);                  // R7 stalled at max: no tc
    cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < 400; i++) begin
      int d = int'($urandom_range(15, 0));
      bit ld = ($urandom_range(7, 0) != 0);
      cyc(($urandom_range(31, 0) == 0), $urandom_range(3, 0) == 0,
          $urandom_range(1, 0) == 1, ld, d);
    end
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule